// File: doc/BRIEF.md
# Bidirectional FIFO port controller

This block joins two dual-clock FIFOs that move data in opposite directions between two synchronous ports, A and B. Each port runs on its own free-running clock and owns a single data bus, modelled here as a separate input, output and output-enable. A port either writes words into the FIFO heading to the other side or reads words out of the FIFO arriving from the other side. The direction is chosen with a chip-select and a write/read select, and the transfer itself is gated by a write enable or a read enable.

The controller decodes each port's controls into a write strobe and a read strobe that the FIFOs sample on the port clock. It drives the bus enable directly from chip-select and write/read select. It also returns to each port an input-ready flag, from the FIFO it feeds, and an output-ready flag, from the FIFO it drains, both in that port's clock domain. The receiving side holds a first-word-fall-through output register, so a high output-ready always means a fresh word is on the port's data output. Each direction has its own synchronous reset.

Top module: `bidir_fifo_port`

## Requirements
- R1: A port's output-enable is high exactly when its chip-select (active low) is 0 and its write/read select is 0 (read mode). It follows those two inputs combinationally and does not depend on the enables.
- R2: On a rising edge of port A's clock with chip-select 0, write/read select 1, write enable 1 and input-ready 1, port A's input word enters the A-to-B FIFO. The words come out at port B in the order they were written. Port B writes into the B-to-A FIFO in the same way on its own clock.
- R3: On a rising edge of a port's clock with chip-select 0, write/read select 0, read enable 1 and output-ready 1, the word on the port's data output is consumed and the next stored word, if any, replaces it at that edge.
- R4: While chip-select is 1, no word is written and none is consumed at that port, whatever the other controls are.
- R5: With both enables at 0, changes on chip-select and write/read select affect only the output-enable. FIFO contents and the data output are unchanged.
- R6: Input-ready falls when the feeding FIFO is full. A write attempted while input-ready is 0 is dropped. With address width AW, one direction holds 2^AW words in memory plus one in the output register.
- R7: A rising output-ready comes with the oldest unread word already on the data output. When the last word is consumed, output-ready falls and the data output keeps that word until a new one arrives.
- R8: The reset of one direction empties only that direction's FIFO. The receiving port's output-ready goes to 0 and the sending port's input-ready returns to 1. The other direction keeps its words.
- R9: A write enable in read mode writes nothing, and a read enable in write mode consumes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_ab | input | 1 | Synchronous active-high reset of the A-to-B direction |
| rst_ba | input | 1 | Synchronous active-high reset of the B-to-A direction |
| a_cs_n | input | 1 | Port A chip-select, active low |
| a_wr_mode | input | 1 | Port A write/read select, 1 = write, 0 = read |
| a_wen | input | 1 | Port A write enable |
| a_ren | input | 1 | Port A read enable |
| a_din | input | DW | Port A bus, inbound |
| a_dout | output | DW | Port A bus, outbound (B-to-A output register) |
| a_oe | output | 1 | Port A bus drive enable |
| a_ir | output | 1 | Port A input-ready (A-to-B not full) |
| a_or | output | 1 | Port A output-ready (new word on a_dout) |
| b_cs_n | input | 1 | Port B chip-select, active low |
| b_wr_mode | input | 1 | Port B write/read select, 1 = write, 0 = read |
| b_wen | input | 1 | Port B write enable |
| b_ren | input | 1 | Port B read enable |
| b_din | input | DW | Port B bus, inbound |
| b_dout | output | DW | Port B bus, outbound (A-to-B output register) |
| b_oe | output | 1 | Port B bus drive enable |
| b_ir | output | 1 | Port B input-ready (B-to-A not full) |
| b_or | output | 1 | Port B output-ready (new word on b_dout) |

## Verification
The assertions check on every cycle that the bus enable stays off outside read mode with the chip selected. They also check that output-ready drops only through a read at that port, that the data output moves only while output-ready is high, that a deselected port holds its output word, and that input-ready falls only right after an accepted write. The bench scenarios show the rest: data order across the two clock domains, the exact capacity at which writes stall and the dropped overflow word, controls ignored in the wrong mode or with the enables low, and a reset that clears one direction and leaves the other untouched.

// File: rtl/bdf_pkg.sv
package bdf_pkg;

  // Control inputs of one port, bundled for the decoder.
  typedef struct packed {
    logic cs_n;     // chip select, active low
    logic wr_mode;  // 1 = port writes, 0 = port reads
    logic wen;      // write enable
    logic ren;      // read enable
  } port_ctl_t;

endpackage

// File: rtl/bdf_sync2.sv
module bdf_sync2 #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/bdf_port_dec.sv
module bdf_port_dec
  import bdf_pkg::*;
(
  input  port_ctl_t ctl,
  input  logic      ir,       // feeding FIFO has room
  input  logic      ordy,     // draining FIFO has a word out
  output logic      oe,
  output logic      wr_stb,
  output logic      rd_stb
);
  logic selected;

  assign selected = !ctl.cs_n;
  assign oe       = selected && !ctl.wr_mode;
  assign wr_stb   = selected &&  ctl.wr_mode && ctl.wen && ir;
  assign rd_stb   = selected && !ctl.wr_mode && ctl.ren && ordy;
endmodule

// File: rtl/bdf_xfifo.sv
module bdf_xfifo #(
  parameter int DW = 18,
  parameter int AW = 9      // must be 2 or more
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [DW-1:0] wdata,
  output logic          ir,
  input  logic          rd_stb,
  output logic [DW-1:0] rdata,
  output logic          ordy
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [DW-1:0] mem [DEPTH];

  logic [PW-1:0] wbin, wgray, wbin_nx, wgray_nx, wgray_s;
  logic [PW-1:0] rbin, rgray, rbin_nx, rgray_s, full_ref;
  logic          mem_has, load;

  // ---------------- write side (wclk) ----------------
  always_ff @(posedge wclk) begin
    if (wr_stb) mem[wbin[AW-1:0]] <= wdata;
  end

  assign wbin_nx  = wbin + PW'(wr_stb);
  assign wgray_nx = wbin_nx ^ (wbin_nx >> 1);
  assign full_ref = {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]};

  always_ff @(posedge wclk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      ir    <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
      ir    <= (wgray_nx != full_ref);
    end
  end

  bdf_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst(rst), .d(wgray), .q(wgray_s));
  bdf_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst(rst), .d(rgray), .q(rgray_s));

  // ---------------- read side (rclk) -----------------
  assign mem_has = (rgray != wgray_s);
  assign load    = mem_has && (!ordy || rd_stb);
  assign rbin_nx = rbin + PW'(1);

  always_ff @(posedge rclk) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
      ordy  <= 1'b0;
      rdata <= '0;
    end else if (load) begin
      rdata <= mem[rbin[AW-1:0]];
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      ordy  <= 1'b1;
    end else if (rd_stb) begin
      ordy  <= 1'b0;     // data kept in rdata
    end
  end
endmodule

// File: rtl/bidir_fifo_port.sv
module bidir_fifo_port
  import bdf_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 9
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_ab,
  input  logic          rst_ba,
  input  logic          a_cs_n,
  input  logic          a_wr_mode,
  input  logic          a_wen,
  input  logic          a_ren,
  input  logic [DW-1:0] a_din,
  output logic [DW-1:0] a_dout,
  output logic          a_oe,
  output logic          a_ir,
  output logic          a_or,
  input  logic          b_cs_n,
  input  logic          b_wr_mode,
  input  logic          b_wen,
  input  logic          b_ren,
  input  logic [DW-1:0] b_din,
  output logic [DW-1:0] b_dout,
  output logic          b_oe,
  output logic          b_ir,
  output logic          b_or
);
  port_ctl_t a_ctl, b_ctl;
  logic      a_wr, a_rd, b_wr, b_rd;

  assign a_ctl = '{cs_n: a_cs_n, wr_mode: a_wr_mode, wen: a_wen, ren: a_ren};
  assign b_ctl = '{cs_n: b_cs_n, wr_mode: b_wr_mode, wen: b_wen, ren: b_ren};

  bdf_port_dec u_dec_a (
    .ctl(a_ctl), .ir(a_ir), .ordy(a_or),
    .oe(a_oe), .wr_stb(a_wr), .rd_stb(a_rd)
  );

  bdf_port_dec u_dec_b (
    .ctl(b_ctl), .ir(b_ir), .ordy(b_or),
    .oe(b_oe), .wr_stb(b_wr), .rd_stb(b_rd)
  );

  // A to B: written on clk_a, read on clk_b
  bdf_xfifo #(.DW(DW), .AW(AW)) u_fifo_ab (
    .wclk(clk_a), .rclk(clk_b), .rst(rst_ab),
    .wr_stb(a_wr), .wdata(a_din), .ir(a_ir),
    .rd_stb(b_rd), .rdata(b_dout), .ordy(b_or)
  );

  // B to A: written on clk_b, read on clk_a
  bdf_xfifo #(.DW(DW), .AW(AW)) u_fifo_ba (
    .wclk(clk_b), .rclk(clk_a), .rst(rst_ba),
    .wr_stb(b_wr), .wdata(b_din), .ir(b_ir),
    .rd_stb(a_rd), .rdata(a_dout), .ordy(a_or)
  );
endmodule

// File: rtl/bdf_chk.sv
module bdf_chk #(
  parameter int DW = 18
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          rst_ab,
  input logic          rst_ba,
  input logic          a_cs_n,
  input logic          a_wr_mode,
  input logic          a_wen,
  input logic          a_ren,
  input logic [DW-1:0] a_dout,
  input logic          a_oe,
  input logic          a_ir,
  input logic          a_or,
  input logic          b_cs_n,
  input logic          b_wr_mode,
  input logic          b_wen,
  input logic          b_ren,
  input logic [DW-1:0] b_dout,
  input logic          b_oe,
  input logic          b_ir,
  input logic          b_or
);
  // R1
  oe_off_a_chk: assert property (@(posedge clk_a) disable iff (rst_ab)
    (a_cs_n || a_wr_mode) |-> !a_oe);
  // R1
  oe_off_b_chk: assert property (@(posedge clk_b) disable iff (rst_ba)
    (b_cs_n || b_wr_mode) |-> !b_oe);
  // R7
  or_hold_a_chk: assert property (@(posedge clk_a) disable iff (rst_ba)
    (a_or && !(!a_cs_n && !a_wr_mode && a_ren)) |=> a_or);
  // R7
  or_hold_b_chk: assert property (@(posedge clk_b) disable iff (rst_ab)
    (b_or && !(!b_cs_n && !b_wr_mode && b_ren)) |=> b_or);
  // R7
  dout_move_a_chk: assert property (@(posedge clk_a) disable iff (rst_ba)
    !$stable(a_dout) |-> a_or);
  // R7
  dout_move_b_chk: assert property (@(posedge clk_b) disable iff (rst_ab)
    !$stable(b_dout) |-> b_or);
  // R4
  desel_keep_a_chk: assert property (@(posedge clk_a) disable iff (rst_ba)
    (a_cs_n && a_or) |=> (a_or && $stable(a_dout)));
  // R4
  desel_keep_b_chk: assert property (@(posedge clk_b) disable iff (rst_ab)
    (b_cs_n && b_or) |=> (b_or && $stable(b_dout)));
  // R6
  ir_fall_a_chk: assert property (@(posedge clk_a) disable iff (rst_ab)
    $fell(a_ir) |-> $past(!a_cs_n && a_wr_mode && a_wen));
  // R6
  ir_fall_b_chk: assert property (@(posedge clk_b) disable iff (rst_ba)
    $fell(b_ir) |-> $past(!b_cs_n && b_wr_mode && b_wen));
endmodule

bind bidir_fifo_port bdf_chk #(.DW(DW)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_ab(rst_ab), .rst_ba(rst_ba),
  .a_cs_n(a_cs_n), .a_wr_mode(a_wr_mode), .a_wen(a_wen), .a_ren(a_ren),
  .a_dout(a_dout), .a_oe(a_oe), .a_ir(a_ir), .a_or(a_or),
  .b_cs_n(b_cs_n), .b_wr_mode(b_wr_mode), .b_wen(b_wen), .b_ren(b_ren),
  .b_dout(b_dout), .b_oe(b_oe), .b_ir(b_ir), .b_or(b_or)
);

// File: tb/sim_bidir_fifo_port.sv
module sim_bidir_fifo_port;
  localparam int DW = 18;
  localparam int AW = 2;
  localparam int CAP = (1 << AW) + 1;

  logic clk = 1'b0;
  logic rst_ab = 1'b1, rst_ba = 1'b1;
  logic a_cs_n = 1'b1, a_wr_mode = 1'b0, a_wen = 1'b0, a_ren = 1'b0;
  logic b_cs_n = 1'b1, b_wr_mode = 1'b0, b_wen = 1'b0, b_ren = 1'b0;
  logic [DW-1:0] a_din = '0, b_din = '0;
  logic [DW-1:0] a_dout, b_dout;
  logic a_oe, a_ir, a_or, b_oe, b_ir, b_or;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz, both ports coincident

  bidir_fifo_port #(.DW(DW), .AW(AW)) u0 (
    .clk_a(clk), .clk_b(clk), .rst_ab(rst_ab), .rst_ba(rst_ba),
    .a_cs_n(a_cs_n), .a_wr_mode(a_wr_mode), .a_wen(a_wen), .a_ren(a_ren),
    .a_din(a_din), .a_dout(a_dout), .a_oe(a_oe), .a_ir(a_ir), .a_or(a_or),
    .b_cs_n(b_cs_n), .b_wr_mode(b_wr_mode), .b_wen(b_wen), .b_ren(b_ren),
    .b_din(b_din), .b_dout(b_dout), .b_oe(b_oe), .b_ir(b_ir), .b_or(b_or)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_a(input logic [DW-1:0] d);
    while (!a_ir) @(negedge clk);
    a_cs_n = 0; a_wr_mode = 1; a_wen = 1; a_din = d;
    @(negedge clk);
    a_wen = 0; a_cs_n = 1;
  endtask

  task automatic push_b(input logic [DW-1:0] d);
    while (!b_ir) @(negedge clk);
    b_cs_n = 0; b_wr_mode = 1; b_wen = 1; b_din = d;
    @(negedge clk);
    b_wen = 0; b_cs_n = 1;
  endtask

  task automatic pop_b(input logic [DW-1:0] exp, input string req);
    for (int w = 0; w < 20 && !b_or; w++) @(negedge clk);
    chk(req, b_or, 1);
    chk(req, b_dout, exp);
    b_cs_n = 0; b_wr_mode = 0; b_ren = 1;
    @(negedge clk);
    b_ren = 0; b_cs_n = 1;
  endtask

  task automatic pop_a(input logic [DW-1:0] exp, input string req);
    for (int w = 0; w < 20 && !a_or; w++) @(negedge clk);
    chk(req, a_or, 1);
    chk(req, a_dout, exp);
    a_cs_n = 0; a_wr_mode = 0; a_ren = 1;
    @(negedge clk);
    a_ren = 0; a_cs_n = 1;
  endtask

  initial begin
    int cnt;
    cyc(5);
    rst_ab = 0; rst_ba = 0;
    cyc(3);
    // R8 reset state
    chk("R8 reset a_or", a_or, 0);
    chk("R8 reset b_or", b_or, 0);
    chk("R8 reset a_ir", a_ir, 1);
    chk("R8 reset b_ir", b_ir, 1);

    // R1 sweep of select inputs on both ports, enables low
    for (int cs = 0; cs < 2; cs++) begin
      for (int md = 0; md < 2; md++) begin
        a_cs_n = cs[0]; a_wr_mode = md[0];
        b_cs_n = cs[0]; b_wr_mode = md[0];
        #2;
        chk("R1 a_oe", a_oe, (cs == 0 && md == 0));
        chk("R1 b_oe", b_oe, (cs == 0 && md == 0));
        @(negedge clk);
      end
    end
    a_cs_n = 1; b_cs_n = 1; a_wr_mode = 0; b_wr_mode = 0;
    cyc(4);
    chk("R5 sweep left A-to-B empty", b_or, 0);

    // R2 / R7 A to B, then drain
    for (int i = 0; i < 3; i++) push_a(18'h10 + 18'(i));
    cyc(8);
    chk("R7 first word with or", b_dout, 18'h10);
    for (int i = 0; i < 3; i++) pop_b(18'h10 + 18'(i), "R2 A-to-B order");
    chk("R7 or low after last read", b_or, 0);
    chk("R7 last word kept", b_dout, 18'h12);

    // R3 B to A, back-to-back reads
    for (int i = 0; i < 3; i++) push_b(18'h20 + 18'(i));
    cyc(8);
    for (int i = 0; i < 3; i++) pop_a(18'h20 + 18'(i), "R3 B-to-A read advance");
    chk("R3 or low after drain", a_or, 0);
    chk("R7 A last word kept", a_dout, 18'h22);

    // R4 deselected reads and writes do nothing
    push_a(18'h400); push_a(18'h401);
    cyc(8);
    b_cs_n = 1; b_wr_mode = 0; b_ren = 1;
    a_cs_n = 1; a_wr_mode = 1; a_wen = 1; a_din = 18'h4FF;
    cyc(5);
    b_ren = 0; a_wen = 0;
    chk("R4 read blocked or", b_or, 1);
    chk("R4 read blocked dout", b_dout, 18'h400);

    // R5 select toggles with enables low
    for (int k = 0; k < 4; k++) begin
      b_cs_n = k[0]; b_wr_mode = k[1];
      @(negedge clk);
    end
    b_cs_n = 1;
    chk("R5 dout unchanged", b_dout, 18'h400);

    // R9 wrong-mode enables
    b_cs_n = 0; b_wr_mode = 1; b_ren = 1;
    a_cs_n = 0; a_wr_mode = 0; a_wen = 1; a_din = 18'h4FE;
    cyc(3);
    b_ren = 0; b_cs_n = 1; a_wen = 0; a_cs_n = 1;
    chk("R9 ren in write mode", b_dout, 18'h400);
    pop_b(18'h400, "R4 drain");
    pop_b(18'h401, "R4 drain");
    cyc(6);
    chk("R4/R9 no extra word written", b_or, 0);

    // R6 fill to capacity
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      if (a_ir) begin
        a_cs_n = 0; a_wr_mode = 1; a_wen = 1; a_din = 18'h300 + 18'(cnt);
        cnt++;
      end else begin
        a_wen = 0;
      end
      @(negedge clk);
    end
    a_wen = 0; a_cs_n = 1;
    cyc(10);
    chk("R6 words accepted", cnt, CAP);
    chk("R6 ir low when full", a_ir, 0);
    a_cs_n = 0; a_wr_mode = 1; a_wen = 1; a_din = 18'h3FF;
    @(negedge clk);
    a_wen = 0; a_cs_n = 1;
    for (int i = 0; i < CAP; i++) pop_b(18'h300 + 18'(i), "R6 stored order");
    cyc(6);
    chk("R6 overflow word dropped", b_or, 0);
    chk("R6 ir back high", a_ir, 1);

    // R8 reset one direction only
    push_a(18'h100); push_a(18'h101);
    push_b(18'h200); push_b(18'h201);
    cyc(8);
    rst_ab = 1;
    cyc(4);
    rst_ab = 0;
    cyc(2);
    chk("R8 cleared b_or", b_or, 0);
    chk("R8 a_ir high", a_ir, 1);
    chk("R8 other direction a_or", a_or, 1);
    chk("R8 other direction a_dout", a_dout, 18'h200);
    cyc(6);
    chk("R8 cleared stays empty", b_or, 0);
    pop_a(18'h200, "R8 other direction kept");
    pop_a(18'h201, "R8 other direction kept");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule